// File: doc/BRIEF.md
# Video encoder output routing controller

This block sits at the back end of a video encoder and turns one 8-bit mode control register into the behaviour of six output sample channels. Software reaches the register over a small parallel bus with an address, write data, a write strobe and a read strobe. Each clock the block takes one sample from each of nine source streams: three RGB components, three luma/colour-difference components (Y, Pb, Pr), composite (CVBS), separate luma and separate chroma. It drives the six output channels through a routing matrix whose layout the register selects.

The same register also sets several things. It chooses whether the TV standard comes from a pin or from a field of another register. It enables the NTSC pedestal. It requests square-pixel operation. It gates pixel data: after reset the outputs show black and master timing is forced, until software declares the pixel data valid. It also puts the back end to sleep. A three-state machine tracks the operating condition. ST_BLANK is the reset state, where the outputs are black. ST_ACTIVE passes data. ST_SLEEP holds the outputs at zero. The transitions are:
- blank-to-active when the data-valid bit is set, and active-to-blank when it is cleared.
- any-to-sleep when a sleep request appears.
- sleep-to-active or sleep-to-blank when the request clears, with the data-valid bit deciding which.
- reset, from any state back to ST_BLANK.

Top module: `vid_route_ctrl`

## Requirements
- R1: The control register sits at bus address 0x02. A write strobe at that address stores the write data at the next clock. While the read strobe is high at that address, `bus_rdata` shows the stored value, and it reads 0 at other times. Writes to any other address change nothing.
- R2: Reset clears the register to 0x00 and puts the state machine in ST_BLANK. With the default register, the first clock after reset puts black levels on all outputs, `sleep_o` is 0 and `timing_slave_o` is 0.
- R3: Register bits {2,1,0} choose the output layout for channels A..F. Write G,B,R for RGB, Y,U,V for luma/colour difference, C for CVBS, L for luma and H for chroma. The layouts are: 000 G,B,R,C,L,H. 001 Y,U,V,C,L,H. 010 and 110 C,L,H,G,B,R. 011 and 111 C,L,H,Y,U,V. 100 C,B,R,G,L,H. 101 C,U,V,Y,L,H.
- R4: While `prog_scan_i` is 1, every channel that would carry G, B or R carries Y, Pb or Pr instead, whatever bit 0 holds.
- R5: When bit 5 is 1, `std_pal_o` equals `std_field_i`. When bit 5 is 0, it equals `std_pin_i`. A value of 0 means NTSC and 1 means PAL.
- R6: `pedestal_o` is bit 3 while the standard is NTSC, and 0 while it is PAL.
- R7: While bit 6 is 0 and the block is awake, channels carrying G, B, R, Y, CVBS or luma output BLACK_Y (64). Channels carrying U, V or chroma output BLACK_C (512). `timing_slave_o` is 0. While bit 6 is 1, samples pass through and `timing_slave_o` follows `timing_slave_req_i`.
- R8: With `pwr_sleep_en_i` at 0, bit 7 set to 1 enters ST_SLEEP one clock after the register is updated. In ST_SLEEP `sleep_o` is 1 and all six outputs are 0. Writing 0 to bit 7 leaves sleep, and so does reset. Register writes and reads keep working while asleep, and the register contents are kept.
- R9: With `pwr_sleep_en_i` at 1, bit 7 is ignored and the block sleeps exactly while `sleep_pin_a_i` and `sleep_pin_b_i` are both 1.
- R10: `sq_pixel_o` is 1 only when bit 4 is 1, `timing_slave_o` is 1 and `os4x_i` is 0.
- R11: Output channels are registered. A new input sample appears one clock later, and a register write changes the outputs at the clock after the one that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data |
| prog_scan_i | input | 1 | Progressive-scan input flag |
| std_pin_i | input | 1 | Standard pin, 0 NTSC, 1 PAL |
| std_field_i | input | 1 | Standard field from the other mode register |
| timing_slave_req_i | input | 1 | Timing register requests slave mode |
| os4x_i | input | 1 | 4x oversampling selected |
| pwr_sleep_en_i | input | 1 | Power-up sleep enable, 1 hands sleep to pins |
| sleep_pin_a_i | input | 1 | First external sleep pin |
| sleep_pin_b_i | input | 1 | Second external sleep pin |
| in_g | input | 10 | Green sample |
| in_b | input | 10 | Blue sample |
| in_r | input | 10 | Red sample |
| in_y | input | 10 | Luma component sample |
| in_pb | input | 10 | Blue colour-difference sample |
| in_pr | input | 10 | Red colour-difference sample |
| in_cvbs | input | 10 | Composite sample |
| in_luma | input | 10 | Separate luma sample |
| in_chroma | input | 10 | Separate chroma sample |
| dac_a | output | 10 | Output channel A |
| dac_b | output | 10 | Output channel B |
| dac_c | output | 10 | Output channel C |
| dac_d | output | 10 | Output channel D |
| dac_e | output | 10 | Output channel E |
| dac_f | output | 10 | Output channel F |
| std_pal_o | output | 1 | Effective standard, 1 PAL |
| pedestal_o | output | 1 | NTSC pedestal active |
| timing_slave_o | output | 1 | Effective timing mode, 1 slave |
| sq_pixel_o | output | 1 | Square-pixel mode active |
| sleep_o | output | 1 | Sleep status |

## Verification
On every cycle the assertions check the following:
- a write at the register address is stored.
- a register sleep request is followed by sleep, and the pin mode leaves the block awake unless both pins are high.
- the outputs are zero throughout sleep.
- no pedestal appears under PAL.
- square-pixel mode never appears outside slave timing or under 4x oversampling.
- master timing holds while the data-valid bit is clear.

Only the bench scenarios can show the remaining behaviour: the exact layout for each of the eight codes, the progressive override, the black-level values, the one-clock latency, readback and retention across sleep, and waking through reset.

// File: rtl/vr_pkg.sv
package vr_pkg;

    localparam int NUM_SRC = 9;
    localparam int NUM_CH  = 6;

    typedef enum logic [1:0] {
        ST_BLANK  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_SLEEP  = 2'd2
    } vr_state_e;

    typedef enum logic [3:0] {
        SRC_G      = 4'd0,
        SRC_B      = 4'd1,
        SRC_R      = 4'd2,
        SRC_Y      = 4'd3,
        SRC_U      = 4'd4,
        SRC_V      = 4'd5,
        SRC_CVBS   = 4'd6,
        SRC_LUMA   = 4'd7,
        SRC_CHROMA = 4'd8
    } vr_src_e;

    // Pick the source for one output channel.
    // layout is {bit2, bit1}; comp_yuv selects the Y/U/V component set.
    function automatic vr_src_e route_pick(input int ch, input logic [1:0] layout,
                                           input logic comp_yuv);
        vr_src_e c0, c1, c2, pick;
        c0 = comp_yuv ? SRC_Y : SRC_G;
        c1 = comp_yuv ? SRC_U : SRC_B;
        c2 = comp_yuv ? SRC_V : SRC_R;
        pick = SRC_CVBS;
        case (layout)
            2'b00: begin
                case (ch)
                    0: pick = c0;
                    1: pick = c1;
                    2: pick = c2;
                    3: pick = SRC_CVBS;
                    4: pick = SRC_LUMA;
                    default: pick = SRC_CHROMA;
                endcase
            end
            2'b10: begin
                case (ch)
                    0: pick = SRC_CVBS;
                    1: pick = c1;
                    2: pick = c2;
                    3: pick = c0;
                    4: pick = SRC_LUMA;
                    default: pick = SRC_CHROMA;
                endcase
            end
            default: begin
                case (ch)
                    0: pick = SRC_CVBS;
                    1: pick = SRC_LUMA;
                    2: pick = SRC_CHROMA;
                    3: pick = c0;
                    4: pick = c1;
                    default: pick = c2;
                endcase
            end
        endcase
        return pick;
    endfunction

    function automatic logic is_chroma_class(input vr_src_e s);
        return (s == SRC_U) || (s == SRC_V) || (s == SRC_CHROMA);
    endfunction

endpackage

// File: rtl/vr_regif.sv
module vr_regif #(
    parameter int          AW       = 5,
    parameter int          RW       = 8,
    parameter logic [AW-1:0] REG_ADDR = 5'h02
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic [RW-1:0] wdata_i,
    input  logic          we_i,
    input  logic          re_i,
    output logic [RW-1:0] rdata_o,
    output logic [RW-1:0] ctrl_o
);

    logic hit;
    assign hit = (addr_i == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o <= '0;
        end else if (we_i && hit) begin
            ctrl_o <= wdata_i;
        end
    end

    assign rdata_o = (re_i && hit) ? ctrl_o : '0;

endmodule

// File: rtl/vr_fsm.sv
module vr_fsm
    import vr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pix_valid_i,
    input  logic      sleep_req_i,
    output logic      dp_blank_o,
    output logic      dp_zero_o,
    output logic      sleep_o
);

    vr_state_e state_q, state_nxt;

    // next-state decision
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_BLANK: begin
                if (sleep_req_i)      state_nxt = ST_SLEEP;
                else if (pix_valid_i) state_nxt = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (sleep_req_i)       state_nxt = ST_SLEEP;
                else if (!pix_valid_i) state_nxt = ST_BLANK;
            end
            ST_SLEEP: begin
                if (!sleep_req_i)
                    state_nxt = pix_valid_i ? ST_ACTIVE : ST_BLANK;
            end
            default: state_nxt = ST_BLANK;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_nxt;
    end

    // outputs: datapath controls follow the state being entered so they
    // line up with the registered output channels
    always_comb begin
        dp_blank_o = 1'b0;
        dp_zero_o  = 1'b0;
        unique case (state_nxt)
            ST_BLANK:  dp_blank_o = 1'b1;
            ST_ACTIVE: dp_blank_o = 1'b0;
            ST_SLEEP:  dp_zero_o  = 1'b1;
            default:   dp_blank_o = 1'b1;
        endcase
    end

    assign sleep_o = (state_q == ST_SLEEP);

endmodule

// File: rtl/vr_xbar.sv
module vr_xbar
    import vr_pkg::*;
#(
    parameter int DW      = 10,
    parameter int BLACK_Y = 64,
    parameter int BLACK_C = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] src_i [NUM_SRC],
    input  logic [1:0]    layout_i,
    input  logic          comp_yuv_i,
    input  logic          blank_i,
    input  logic          zero_i,
    output logic [DW-1:0] ch_o  [NUM_CH]
);

    localparam logic [DW-1:0] BLK_Y = DW'(BLACK_Y);
    localparam logic [DW-1:0] BLK_C = DW'(BLACK_C);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        vr_src_e       sel;
        logic [DW-1:0] val;

        always_comb begin
            sel = route_pick(ch, layout_i, comp_yuv_i);
            if (zero_i)
                val = '0;
            else if (blank_i)
                val = is_chroma_class(sel) ? BLK_C : BLK_Y;
            else
                val = src_i[int'(sel)];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_o[ch] <= '0;
            else        ch_o[ch] <= val;
        end
    end

endmodule

// File: rtl/vid_route_ctrl.sv
module vid_route_ctrl
    import vr_pkg::*;
#(
    parameter int            DW       = 10,
    parameter int            AW       = 5,
    parameter logic [AW-1:0] REG_ADDR = 5'h02,
    parameter int            BLACK_Y  = 64,
    parameter int            BLACK_C  = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          bus_we,
    input  logic          bus_re,
    output logic [7:0]    bus_rdata,
    input  logic          prog_scan_i,
    input  logic          std_pin_i,
    input  logic          std_field_i,
    input  logic          timing_slave_req_i,
    input  logic          os4x_i,
    input  logic          pwr_sleep_en_i,
    input  logic          sleep_pin_a_i,
    input  logic          sleep_pin_b_i,
    input  logic [DW-1:0] in_g,
    input  logic [DW-1:0] in_b,
    input  logic [DW-1:0] in_r,
    input  logic [DW-1:0] in_y,
    input  logic [DW-1:0] in_pb,
    input  logic [DW-1:0] in_pr,
    input  logic [DW-1:0] in_cvbs,
    input  logic [DW-1:0] in_luma,
    input  logic [DW-1:0] in_chroma,
    output logic [DW-1:0] dac_a,
    output logic [DW-1:0] dac_b,
    output logic [DW-1:0] dac_c,
    output logic [DW-1:0] dac_d,
    output logic [DW-1:0] dac_e,
    output logic [DW-1:0] dac_f,
    output logic          std_pal_o,
    output logic          pedestal_o,
    output logic          timing_slave_o,
    output logic          sq_pixel_o,
    output logic          sleep_o
);

    // control register bit positions
    localparam int B_YUV   = 0;
    localparam int B_PED   = 3;
    localparam int B_SQPX  = 4;
    localparam int B_STDR  = 5;
    localparam int B_VALID = 6;
    localparam int B_SLEEP = 7;

    logic [7:0]    ctrl_q;
    logic          sleep_req;
    logic          dp_blank, dp_zero;
    logic [DW-1:0] src   [NUM_SRC];
    logic [DW-1:0] chans [NUM_CH];

    vr_regif #(.AW(AW), .RW(8), .REG_ADDR(REG_ADDR)) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .we_i    (bus_we),
        .re_i    (bus_re),
        .rdata_o (bus_rdata),
        .ctrl_o  (ctrl_q)
    );

    assign sleep_req = pwr_sleep_en_i ? (sleep_pin_a_i && sleep_pin_b_i)
                                      : ctrl_q[B_SLEEP];

    vr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid_i (ctrl_q[B_VALID]),
        .sleep_req_i (sleep_req),
        .dp_blank_o  (dp_blank),
        .dp_zero_o   (dp_zero),
        .sleep_o     (sleep_o)
    );

    assign src[SRC_G]      = in_g;
    assign src[SRC_B]      = in_b;
    assign src[SRC_R]      = in_r;
    assign src[SRC_Y]      = in_y;
    assign src[SRC_U]      = in_pb;
    assign src[SRC_V]      = in_pr;
    assign src[SRC_CVBS]   = in_cvbs;
    assign src[SRC_LUMA]   = in_luma;
    assign src[SRC_CHROMA] = in_chroma;

    vr_xbar #(.DW(DW), .BLACK_Y(BLACK_Y), .BLACK_C(BLACK_C)) u_xbar (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src),
        .layout_i   (ctrl_q[2:1]),
        .comp_yuv_i (ctrl_q[B_YUV] | prog_scan_i),
        .blank_i    (dp_blank),
        .zero_i     (dp_zero),
        .ch_o       (chans)
    );

    assign dac_a = chans[0];
    assign dac_b = chans[1];
    assign dac_c = chans[2];
    assign dac_d = chans[3];
    assign dac_e = chans[4];
    assign dac_f = chans[5];

    assign std_pal_o      = ctrl_q[B_STDR] ? std_field_i : std_pin_i;
    assign pedestal_o     = ctrl_q[B_PED] && !std_pal_o;
    assign timing_slave_o = ctrl_q[B_VALID] && timing_slave_req_i;
    assign sq_pixel_o     = ctrl_q[B_SQPX] && timing_slave_o && !os4x_i;

endmodule

// File: rtl/vr_route_chk.sv
module vr_route_chk #(
    parameter int            DW       = 10,
    parameter int            AW       = 5,
    parameter logic [AW-1:0] REG_ADDR = 5'h02
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          bus_we,
    input logic [7:0]    ctrl_q,
    input logic          pwr_sleep_en_i,
    input logic          sleep_pin_a_i,
    input logic          sleep_pin_b_i,
    input logic          os4x_i,
    input logic [DW-1:0] dac_a,
    input logic [DW-1:0] dac_b,
    input logic [DW-1:0] dac_c,
    input logic [DW-1:0] dac_d,
    input logic [DW-1:0] dac_e,
    input logic [DW-1:0] dac_f,
    input logic          std_pal_o,
    input logic          pedestal_o,
    input logic          timing_slave_o,
    input logic          sq_pixel_o,
    input logic          sleep_o
);

    p_write_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_ADDR) |=> (ctrl_q == $past(bus_wdata)));

    p_pal_no_ped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        std_pal_o |-> !pedestal_o);

    p_master_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[6] |-> !timing_slave_o);

    p_sleep_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_sleep_en_i && ctrl_q[7]) |=> sleep_o);

    p_sleep_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> (dac_a == '0 && dac_b == '0 && dac_c == '0 &&
                     dac_d == '0 && dac_e == '0 && dac_f == '0));

    p_pins_awake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_sleep_en_i && !(sleep_pin_a_i && sleep_pin_b_i)) |=> !sleep_o);

    p_sq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sq_pixel_o |-> (timing_slave_o && !os4x_i));

endmodule

bind vid_route_ctrl vr_route_chk #(.DW(DW), .AW(AW), .REG_ADDR(REG_ADDR)) u_chk (.*);

// File: tb/sim_vid_route_ctrl.sv
`timescale 1ns/1ps
module sim_vid_route_ctrl;

    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    bus_addr = 5'h02;
    logic [7:0]    bus_wdata = '0;
    logic          bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0]    bus_rdata;
    logic          prog_scan_i = 0, std_pin_i = 0, std_field_i = 0;
    logic          timing_slave_req_i = 0, os4x_i = 0, pwr_sleep_en_i = 0;
    logic          sleep_pin_a_i = 0, sleep_pin_b_i = 0;
    logic [DW-1:0] in_g, in_b, in_r, in_y, in_pb, in_pr, in_cvbs, in_luma, in_chroma;
    logic [DW-1:0] dac_a, dac_b, dac_c, dac_d, dac_e, dac_f;
    logic          std_pal_o, pedestal_o, timing_slave_o, sq_pixel_o, sleep_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vid_route_ctrl u0 (.*);

    // source codes: G1 B2 R3 Y4 U5 V6 CVBS7 LUMA8 CHROMA9; sample = code*16+3
    function automatic logic [DW-1:0] sval(input int code);
        return DW'(code * 16 + 3);
    endfunction

    initial begin
        in_g = sval(1); in_b = sval(2); in_r = sval(3);
        in_y = sval(4); in_pb = sval(5); in_pr = sval(6);
        in_cvbs = sval(7); in_luma = sval(8); in_chroma = sval(9);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_route(input string req, input logic [23:0] exp);
        chk(req, dac_a, sval(int'(exp[23:20])));
        chk(req, dac_b, sval(int'(exp[19:16])));
        chk(req, dac_c, sval(int'(exp[15:12])));
        chk(req, dac_d, sval(int'(exp[11:8])));
        chk(req, dac_e, sval(int'(exp[7:4])));
        chk(req, dac_f, sval(int'(exp[3:0])));
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 5'h02;
    endtask

    task automatic rd_chk(input string req, input int exp);
        bus_re = 1'b1; #1;
        chk(req, bus_rdata, exp);
        bus_re = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // {ctrl[7:0], prog, expected codes A..F}
    localparam logic [32:0] VEC [11] = '{
        {8'h40, 1'b0, 24'h123789},
        {8'h41, 1'b0, 24'h456789},
        {8'h42, 1'b0, 24'h789123},
        {8'h43, 1'b0, 24'h789456},
        {8'h44, 1'b0, 24'h723189},
        {8'h45, 1'b0, 24'h756489},
        {8'h46, 1'b0, 24'h789123},
        {8'h47, 1'b0, 24'h789456},
        {8'h40, 1'b1, 24'h456789},
        {8'h44, 1'b1, 24'h756489},
        {8'h42, 1'b1, 24'h789456}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state and R7 blanking defaults
        timing_slave_req_i = 1'b1;
        #1;
        rd_chk("R2 reset readback", 0);
        chk("R2 sleep after reset", sleep_o, 0);
        chk("R2 master timing after reset", timing_slave_o, 0);
        chk("R7 black luma class on A", dac_a, 64);
        chk("R7 black chroma class on F", dac_f, 512);
        chk("R7 black chroma-class B? (B is blue, luma class)", dac_b, 64);

        // R3 / R4 routing table
        foreach (VEC[i]) begin
            prog_scan_i = VEC[i][24];
            wr(5'h02, VEC[i][32:25]);
            @(negedge clk);
            chk_route(VEC[i][24] ? "R4 progressive override" : "R3 layout", VEC[i][23:0]);
        end
        prog_scan_i = 1'b0;

        // R1 readback and foreign address ignored
        rd_chk("R1 readback", 8'h42);
        wr(5'h03, 8'h01);
        rd_chk("R1 other address ignored", 8'h42);
        @(negedge clk);
        chk_route("R1 other address ignored routing", 24'h789123);

        // R7 timing follows request when valid
        chk("R7 slave timing when valid", timing_slave_o, 1);

        // R11 latency: sample and register write
        wr(5'h02, 8'h40);
        @(negedge clk);
        in_g = 10'd999; #1;
        chk("R11 output holds before edge", dac_a, sval(1));
        @(negedge clk);
        chk("R11 output one clock later", dac_a, 999);
        in_g = sval(1);
        @(negedge clk);
        bus_wdata = 8'h00; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R11 write not yet visible", dac_a, sval(1));
        @(negedge clk);
        chk("R11 write visible next clock", dac_a, 64);

        // R5 standard arbitration
        std_pin_i = 1; std_field_i = 0; #1;
        chk("R5 pin PAL", std_pal_o, 1);
        std_pin_i = 0; #1;
        chk("R5 pin NTSC", std_pal_o, 0);
        wr(5'h02, 8'h28);
        std_field_i = 1; #1;
        chk("R5 field PAL", std_pal_o, 1);
        // R6 pedestal
        chk("R6 pedestal off under PAL", pedestal_o, 0);
        std_field_i = 0; #1;
        chk("R6 pedestal on under NTSC", pedestal_o, 1);

        // R10 square pixel
        wr(5'h02, 8'h50);
        timing_slave_req_i = 1; os4x_i = 0; #1;
        chk("R10 square pixel active", sq_pixel_o, 1);
        os4x_i = 1; #1;
        chk("R10 blocked by 4x", sq_pixel_o, 0);
        os4x_i = 0; timing_slave_req_i = 0; #1;
        chk("R10 blocked in master", sq_pixel_o, 0);

        // R8 register sleep
        wr(5'h02, 8'hC0);
        @(negedge clk);
        chk("R8 sleep entered", sleep_o, 1);
        chk("R8 outputs zero A", dac_a, 0);
        chk("R8 outputs zero F", dac_f, 0);
        rd_chk("R8 readback while asleep", 8'hC0);
        wr(5'h02, 8'h41);
        rd_chk("R8 write while asleep", 8'h41);
        @(negedge clk);
        chk("R8 sleep left", sleep_o, 0);
        chk_route("R8 routing after wake", 24'h456789);

        // R8 reset leaves sleep
        wr(5'h02, 8'hC0);
        @(negedge clk);
        chk("R8 asleep before reset", sleep_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset wakes", sleep_o, 0);
        chk("R8 reset wakes black output", dac_a, 64);

        // R9 pin-controlled sleep
        pwr_sleep_en_i = 1'b1;
        wr(5'h02, 8'hC0);
        @(negedge clk);
        chk("R9 bit7 ignored", sleep_o, 0);
        sleep_pin_a_i = 1; sleep_pin_b_i = 0;
        @(negedge clk);
        chk("R9 one pin not enough", sleep_o, 0);
        sleep_pin_b_i = 1;
        @(negedge clk); @(negedge clk);
        chk("R9 both pins sleep", sleep_o, 1);
        chk("R9 outputs zero", dac_c, 0);
        sleep_pin_a_i = 0;
        @(negedge clk); @(negedge clk);
        chk("R9 pins release", sleep_o, 0);

        done = 1;
        finish_run();
    end

endmodule